// File: doc/BRIEF.md
# Expansion Card Autoconfiguration Responder

This block is the configuration front end of a plug-in card on a daisy-chained expansion bus. After reset the card sits in an unconfigured state, holds its chain output negated and ignores the bus. When its chain input is asserted, it answers accesses inside a fixed 64 KB configuration window. There it serves a small read-only descriptor table, one nybble per access. It then accepts either a base-address assignment or a shut-up command. Either of these releases the chain output, so the next card in the chain can take its turn.

Each logical register is 8 bits wide and is split into a high and a low nybble at two paired addresses. In the 16-bit bus variant the pair sits at offsets N and N+2 inside the window at 0x00E8xxxx. In the 32-bit variant the pair sits at N and N+0x100 inside the window selected by address bits 31..24 = 0xFF. A parameter picks one variant per instance. Register 00 is returned as stored. Every other register is returned bit-inverted, so offsets with no implemented register read as all ones.

Top module: `autocfg_responder`

## Requirements
- R1: While rst_n is low, and at the first edge after it rises, cfg_out_n is 1, configured and shut_up are 0, base_addr is 0 and rd_oe is 0.
- R2: While cfg_in_n is 1 the block ignores reads (rd_oe stays 0) and writes (no state, base or cfg_out_n change).
- R3: With BUS32=0 the window is addr[31:16]=0x00E8, with addr[15:8]=0 and addr[0]=0. With BUS32=1 the window is addr[31:24]=0xFF, with addr[23:16] ignored, addr[15:9]=0 and addr[1:0]=0. Accesses outside the window get no response.
- R4: A read strobe on a window address drives rd_oe=1 and rd_nyb on the next clock edge. Register k sits at offset 4k. Its high nybble is at offset 4k, and its low nybble is at 4k+2 (BUS32=0) or 4k+0x100 (BUS32=1).
- R5: Register 0 reads as its stored byte. Every other register reads as the bitwise complement of its logical byte.
- R6: Register k for k < NUM_REGS takes its logical byte from DESC[8k+7:8k]. All other offsets, including the write-only ones, are logically 0 and so read 0xF.
- R7: A write to the base register (default offset 0x48) at its high-nybble address only latches that nybble; cfg_out_n stays 1. A write at its low-nybble address sets base_addr = {high, low} and configured=1, and drives cfg_out_n=0 at that edge.
- R8: A write of any value to either half of the shut-up register (default offset 0x4C) sets shut_up=1 and cfg_out_n=0, and leaves base_addr and configured unchanged.
- R9: Once configured or shut up, the block ignores all window reads and writes until the next reset, and keeps base_addr, configured, shut_up and cfg_out_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_n | input | 1 | Chain enable from the previous card, active low |
| addr | input | 32 | Bus address |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_nyb | input | 4 | Upper data nybble for writes |
| rd_nyb | output | 4 | Upper data nybble returned by reads |
| rd_oe | output | 1 | rd_nyb valid and driven; lower data bits are never driven |
| cfg_out_n | output | 1 | Chain enable to the next card, active low |
| base_addr | output | 8 | Assigned base address byte |
| configured | output | 1 | Base address has been assigned |
| shut_up | output | 1 | Card has been told to stay off the bus |

## Verification
A wrong configuration state shows up in the very next access. A card that wakes too early, or stays awake after assignment, raises rd_oe one cycle after a read strobe when it should stay quiet. A lost high-nybble latch or a wrong pairing stride shows as a wrong base_addr, or as a wrong nybble, on the edge right after the second write or the read. A premature chain release appears at once on cfg_out_n, and so also on the downstream card, which starts to answer reads in its own window.

// File: rtl/autocfg_pkg.sv
package autocfg_pkg;

   typedef enum logic [1:0] {
      ST_UNCFG  = 2'd0,
      ST_CONFIG = 2'd1,
      ST_SHUTUP = 2'd2
   } cfg_state_e;

   localparam int unsigned REG_W  = 8;
   localparam int unsigned NYB_W  = 4;
   localparam int unsigned IDX_W  = 6;

   function automatic logic [NYB_W-1:0] pick_nyb(input logic [REG_W-1:0] v,
                                                 input logic lo_half);
      return lo_half ? v[NYB_W-1:0] : v[REG_W-1:NYB_W];
   endfunction

endpackage

// File: rtl/acfg_decode.sv
module acfg_decode
   import autocfg_pkg::*;
#(
   parameter bit BUS32  = 1'b0,
   parameter int ADDR_W = 32
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              sel,
   output logic              lo_half,
   output logic [IDX_W-1:0]  idx
);

   if (ADDR_W != 32) begin : g_bad_aw
      $error("acfg_decode: ADDR_W must be 32");
   end

   if (BUS32) begin : g_w32
      // window by A31..A24 only, pair stride 0x100
      always_comb begin
         sel     = (addr[31:24] == 8'hFF) && (addr[15:9] == 7'd0) && (addr[1:0] == 2'd0);
         lo_half = addr[8];
         idx     = addr[7:2];
      end
   end else begin : g_w16
      // 64 KB window at 0x00E8xxxx, pair stride 2
      always_comb begin
         sel     = (addr[31:16] == 16'h00E8) && (addr[15:8] == 8'd0) && !addr[0];
         lo_half = addr[1];
         idx     = addr[7:2];
      end
   end

endmodule

// File: rtl/acfg_rom.sv
module acfg_rom
   import autocfg_pkg::*;
#(
   parameter int                      NUM_REGS = 16,
   parameter logic [NUM_REGS*8-1:0]   DESC     = '0
)(
   input  logic [IDX_W-1:0] idx,
   input  logic             lo_half,
   output logic [NYB_W-1:0] nyb
);

   localparam int MAX_REGS = 1 << IDX_W;

   if (NUM_REGS < 1 || NUM_REGS > MAX_REGS) begin : g_bad_n
      $error("acfg_rom: NUM_REGS out of range");
   end

   logic [REG_W-1:0] logical;
   logic [NYB_W-1:0] raw;

   always_comb begin
      logical = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == i[IDX_W-1:0]) logical = DESC[i*REG_W +: REG_W];
      end
   end

   always_comb begin
      raw = pick_nyb(logical, lo_half);
      nyb = (idx == '0) ? raw : ~raw;
   end

endmodule

// File: rtl/acfg_ctrl.sv
module acfg_ctrl
   import autocfg_pkg::*;
#(
   parameter int BASE_OFS = 'h48,
   parameter int SHUT_OFS = 'h4C
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_in_n,
   input  logic             wr_stb,
   input  logic             sel,
   input  logic             lo_half,
   input  logic [IDX_W-1:0] idx,
   input  logic [NYB_W-1:0] wr_nyb,
   output logic             active,
   output logic             configured,
   output logic             shut_up,
   output logic [REG_W-1:0] base_addr,
   output logic             cfg_out_n
);

   localparam logic [IDX_W-1:0] BASE_I = IDX_W'(BASE_OFS >> 2);
   localparam logic [IDX_W-1:0] SHUT_I = IDX_W'(SHUT_OFS >> 2);

   if ((BASE_OFS % 4) != 0 || (SHUT_OFS % 4) != 0 || BASE_OFS == SHUT_OFS ||
       BASE_OFS > 'hFC || SHUT_OFS > 'hFC) begin : g_bad_ofs
      $error("acfg_ctrl: bad write register offsets");
   end

   cfg_state_e       state_q;
   logic [NYB_W-1:0] hi_q;
   logic [REG_W-1:0] base_q;
   logic             cout_n_q;
   logic             wr_hit;

   assign active = (state_q == ST_UNCFG) && !cfg_in_n;
   assign wr_hit = active && wr_stb && sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_UNCFG;
         hi_q     <= '0;
         base_q   <= '0;
         cout_n_q <= 1'b1;
      end else if (wr_hit) begin
         if (idx == SHUT_I) begin
            state_q  <= ST_SHUTUP;
            cout_n_q <= 1'b0;
         end else if (idx == BASE_I && !lo_half) begin
            hi_q <= wr_nyb;
         end else if (idx == BASE_I && lo_half) begin
            base_q   <= {hi_q, wr_nyb};
            state_q  <= ST_CONFIG;
            cout_n_q <= 1'b0;
         end
      end
   end

   assign configured = (state_q == ST_CONFIG);
   assign shut_up    = (state_q == ST_SHUTUP);
   assign base_addr  = base_q;
   assign cfg_out_n  = cout_n_q;

   // R7 R8
   chain_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_out_n) |-> $past(wr_stb && !cfg_in_n));

   // R7
   cfg_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(configured) |-> $past(wr_stb && lo_half));

   // R9
   frozen_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (configured || shut_up) |=> ($stable(base_addr) && $stable(configured) &&
                                   $stable(shut_up) && !cfg_out_n));

endmodule

// File: rtl/autocfg_responder.sv
module autocfg_responder
   import autocfg_pkg::*;
#(
   parameter bit                     BUS32    = 1'b0,
   parameter int                     NUM_REGS = 16,
   parameter logic [NUM_REGS*8-1:0]  DESC     = {(NUM_REGS*8){1'b0}},
   parameter int                     BASE_OFS = 'h48,
   parameter int                     SHUT_OFS = 'h4C
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_in_n,
   input  logic [31:0] addr,
   input  logic        rd_stb,
   input  logic        wr_stb,
   input  logic [3:0]  wr_nyb,
   output logic [3:0]  rd_nyb,
   output logic        rd_oe,
   output logic        cfg_out_n,
   output logic [7:0]  base_addr,
   output logic        configured,
   output logic        shut_up
);

   if (BASE_OFS < NUM_REGS * 4 || SHUT_OFS < NUM_REGS * 4) begin : g_bad_map
      $error("autocfg_responder: write registers overlap descriptor table");
   end

   logic             sel, lo_half, active;
   logic [IDX_W-1:0] idx;
   logic [NYB_W-1:0] rom_nyb;
   logic [NYB_W-1:0] rd_q;
   logic             oe_q;

   acfg_decode #(.BUS32(BUS32), .ADDR_W(32)) u_dec (
      .addr(addr), .sel(sel), .lo_half(lo_half), .idx(idx));

   acfg_rom #(.NUM_REGS(NUM_REGS), .DESC(DESC)) u_rom (
      .idx(idx), .lo_half(lo_half), .nyb(rom_nyb));

   acfg_ctrl #(.BASE_OFS(BASE_OFS), .SHUT_OFS(SHUT_OFS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_in_n(cfg_in_n), .wr_stb(wr_stb),
      .sel(sel), .lo_half(lo_half), .idx(idx), .wr_nyb(wr_nyb),
      .active(active), .configured(configured), .shut_up(shut_up),
      .base_addr(base_addr), .cfg_out_n(cfg_out_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
         rd_q <= '0;
      end else begin
         oe_q <= rd_stb && sel && active;
         rd_q <= rom_nyb;
      end
   end

   assign rd_oe  = oe_q;
   assign rd_nyb = rd_q;

   // R2
   read_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> $past(rd_stb && !cfg_in_n));

   // R1
   chain_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_out_n |-> (configured || shut_up));

endmodule

// File: tb/test_autocfg_responder.sv
`timescale 1ns/100ps
module test_autocfg_responder;

   localparam logic [127:0] TB_DESC = 128'h0011_0000_7700_0000_6B1F_2E90_4013_D5C2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cin_a_n = 1'b1;
   logic [31:0] addr = '0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [3:0]  wd = '0;

   logic [3:0] a_nyb, b_nyb;
   logic       a_oe, b_oe, a_cout_n, b_cout_n, a_cfg, b_cfg, a_shut, b_shut;
   logic [7:0] a_base, b_base;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   autocfg_responder #(.BUS32(1'b0), .NUM_REGS(16), .DESC(TB_DESC)) i_autocfg_responder (
      .clk(clk), .rst_n(rst_n), .cfg_in_n(cin_a_n), .addr(addr), .rd_stb(rd),
      .wr_stb(wr), .wr_nyb(wd), .rd_nyb(a_nyb), .rd_oe(a_oe), .cfg_out_n(a_cout_n),
      .base_addr(a_base), .configured(a_cfg), .shut_up(a_shut));

   autocfg_responder #(.BUS32(1'b1), .NUM_REGS(16), .DESC(TB_DESC)) i_autocfg_responder_w32 (
      .clk(clk), .rst_n(rst_n), .cfg_in_n(a_cout_n), .addr(addr), .rd_stb(rd),
      .wr_stb(wr), .wr_nyb(wd), .rd_nyb(b_nyb), .rd_oe(b_oe), .cfg_out_n(b_cout_n),
      .base_addr(b_base), .configured(b_cfg), .shut_up(b_shut));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_nyb(input int k, input bit lo);
      logic [7:0] b;
      logic [3:0] n;
      b = (k < 16) ? TB_DESC[k*8 +: 8] : 8'h00;
      n = lo ? b[3:0] : b[7:4];
      return (k == 0) ? n : ~n;
   endfunction

   task automatic rd_op(input logic [31:0] a);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic wr_op(input logic [31:0] a, input logic [3:0] d);
      @(negedge clk); addr = a; wd = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 a cout_n", a_cout_n, 1); chk("R1 b cout_n", b_cout_n, 1);
      chk("R1 a cfg", a_cfg, 0);       chk("R1 a shut", a_shut, 0);
      chk("R1 b cfg", b_cfg, 0);       chk("R1 b shut", b_shut, 0);
      chk("R1 a base", a_base, 0);     chk("R1 b base", b_base, 0);
      chk("R1 a oe", a_oe, 0);         chk("R1 b oe", b_oe, 0);
   endtask

   task automatic t_silent;
      rd_op(32'h00E8_0000); chk("R2 a read ignored", a_oe, 0);
      rd_op(32'hFF00_0000); chk("R2 b read ignored (chain)", b_oe, 0);
      wr_op(32'h00E8_004A, 4'h5);
      chk("R2 a write ignored cfg", a_cfg, 0);
      chk("R2 a write ignored cout", a_cout_n, 1);
      chk("R2 a write ignored base", a_base, 0);
   endtask

   task automatic t_window;
      cin_a_n = 1'b0;
      rd_op(32'h00E9_0000); chk("R3 a outside window", a_oe, 0);
      rd_op(32'hFF00_0000); chk("R3 a other mode window", a_oe, 0);
      chk("R2 b still gated", b_oe, 0);
      rd_op(32'h00E8_0001); chk("R3 a odd address", a_oe, 0);
   endtask

   task automatic t_desc16;
      for (int k = 0; k < 18; k++) begin
         for (int h = 0; h < 2; h++) begin
            rd_op(32'h00E8_0000 + 32'(k*4) + 32'(h*2));
            chk("R4 a oe", a_oe, 1);
            chk((k >= 16) ? "R6 a unimpl nyb" : (k == 0) ? "R5 a reg0 true" : "R5 a inverted nyb",
                a_nyb, exp_nyb(k, h[0]));
         end
      end
   endtask

   task automatic t_base16;
      wr_op(32'h00E8_0048, 4'hA);
      chk("R7 hi only cout_n", a_cout_n, 1);
      chk("R7 hi only cfg", a_cfg, 0);
      wr_op(32'h00E8_004A, 4'h5);
      chk("R7 base", a_base, 8'hA5);
      chk("R7 cfg", a_cfg, 1);
      chk("R7 cout_n", a_cout_n, 0);
      chk("R7 no shut", a_shut, 0);
      rd_op(32'h00E8_0000); chk("R9 a read after cfg", a_oe, 0);
      wr_op(32'h00E8_004C, 4'h0); chk("R9 a shut after cfg", a_shut, 0);
      wr_op(32'h00E8_004A, 4'h3); chk("R9 a base frozen", a_base, 8'hA5);
   endtask

   task automatic t_desc32;
      for (int k = 0; k < 18; k++) begin
         for (int h = 0; h < 2; h++) begin
            rd_op(32'hFF00_0000 + 32'(k*4) + 32'(h*256));
            chk("R4 b oe", b_oe, 1);
            chk((k >= 16) ? "R6 b unimpl nyb" : (k == 0) ? "R5 b reg0 true" : "R5 b inverted nyb",
                b_nyb, exp_nyb(k, h[0]));
         end
      end
      rd_op(32'hFF7F_0104);
      chk("R3 b alias oe", b_oe, 1);
      chk("R3 b alias nyb", b_nyb, exp_nyb(1, 1'b1));
      chk("R9 a silent in b window", a_oe, 0);
   endtask

   task automatic t_shut32;
      wr_op(32'hFF00_014C, 4'h0);
      chk("R8 b shut", b_shut, 1);
      chk("R8 b cout_n", b_cout_n, 0);
      chk("R8 b base", b_base, 0);
      chk("R8 b cfg", b_cfg, 0);
      rd_op(32'hFF00_0000); chk("R9 b read after shut", b_oe, 0);
      wr_op(32'hFF00_014A, 4'h7); chk("R9 b base frozen", b_base, 0);
   endtask

   initial begin : watchdog
      #(5ns * 20000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_silent;
      t_window;
      t_desc16;
      t_base16;
      t_desc32;
      t_shut32;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      t_reset;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule